// File: doc/BRIEF.md
# Shared Sense-Pin Overtemperature / Overvoltage Monitor

This block lets one external sense pin serve two protection checks by time-sharing it. During a heat-check phase the pin is fed by an external current source through a thermistor network. A low pin voltage in that phase means the part is too hot. During a voltage-check phase the pin is loaded by an internal pull-down resistor. A high pin voltage in that phase means an overvoltage. The block selects which element is attached to the pin. It samples a one-bit threshold comparator. It reports two latched fault flags and a combined shutdown request.

Each phase lasts a fixed number of switching cycles, given by a parameter with a default of four. Every switching cycle is marked by a one-clock start strobe. The comparator is judged only at the strobe that closes the last cycle of a phase, so the source has time to settle. A startup flag raises the comparator reference during heat checks. The block drives a reference-select output for this purpose. The analog parts are outside the block: the current source, the resistor, the comparator and the two references.

Top module: `sdm_monitor`

## Requirements
- R1: While `rst` is high at a clock edge, the registers reset. After that edge `src_sel`=1 (heat-check phase, current source attached), `thr_hi`=0, `otp_fault`=0, `ovp_fault`=0 and `shutdown`=0. The cycle count inside the phase is zero.
- R2: `src_sel` changes only at a clock edge where `cyc_start` is high. It toggles on every PH_CYCLES-th strobe after reset. It is 1 in the heat-check phase and 0 in the voltage-check phase.
- R3: At the strobe that closes the last cycle of a heat-check phase, `cmp_hi`=0 (pin below reference) sets `otp_fault` at that edge.
- R4: At the strobe that closes the last cycle of a voltage-check phase, `cmp_hi`=1 (pin above reference) sets `ovp_fault` at that edge.
- R5: `cmp_hi` has no effect at any other strobe or in any cycle without a strobe.
- R6: The passing levels set no fault. These are `cmp_hi`=1 in a heat check and `cmp_hi`=0 in a voltage check.
- R7: `thr_hi` is 1 exactly when `startup` is high and the phase after the edge is the heat-check phase. It is registered, so it follows `startup` one edge later.
- R8: Once set, `otp_fault` and `ovp_fault` stay set until `rst`.
- R9: `shutdown` is the OR of the two fault flags and changes at the same edge as they do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cyc_start | input | 1 | One-clock strobe at the start of each switching cycle |
| startup | input | 1 | High while the controller is in its startup period |
| cmp_hi | input | 1 | Comparator output, 1 when the pin is above the selected reference |
| src_sel | output | 1 | 1 attaches the current source, 0 attaches the pull-down resistor |
| thr_hi | output | 1 | 1 selects the raised startup reference |
| otp_fault | output | 1 | Latched overtemperature fault |
| ovp_fault | output | 1 | Latched overvoltage fault |
| shutdown | output | 1 | Shutdown request, the OR of the two faults |

## Verification
Every result is registered once, so it appears on the first clock edge after the stimulus. For faults and phase changes the stimulus is the strobe. For `thr_hi` it is the change of `startup`. The bench drives inputs on the falling edge and reads outputs on the next falling edge, half a period after the edge that must update them. The sweep places a judged comparator value at every strobe position across two full phases. The expected flags come from the strobe index by division and remainder. It also holds failing comparator levels through idle cycles to show that they are ignored.

// File: rtl/sdm_pkg.sv
package sdm_pkg;
  typedef enum logic [0:0] {
    PH_HEAT = 1'b0,
    PH_VOLT = 1'b1
  } phase_t;
endpackage

// File: rtl/sdm_phase_ctr.sv
module sdm_phase_ctr
  import sdm_pkg::*;
#(
  parameter int PH_CYCLES = 4
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   adv,
  output phase_t phase,
  output phase_t phase_nxt,
  output logic   at_last
);
  localparam int CW = (PH_CYCLES > 1) ? $clog2(PH_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(PH_CYCLES - 1);

  logic [CW-1:0] cnt;

  assign at_last = (cnt == LAST);

  always_comb begin
    phase_nxt = phase;
    if (adv && at_last)
      phase_nxt = (phase == PH_HEAT) ? PH_VOLT : PH_HEAT;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      phase <= PH_HEAT;
    end else if (adv) begin
      cnt   <= at_last ? '0 : cnt + 1'b1;
      phase <= phase_nxt;
    end
  end
endmodule

// File: rtl/sdm_fault_judge.sv
module sdm_fault_judge
  import sdm_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   judge,
  input  phase_t phase,
  input  logic   cmp_hi,
  output logic   otp_q,
  output logic   ovp_q,
  output logic   otp_nxt,
  output logic   ovp_nxt
);
  assign otp_nxt = otp_q | (judge && phase == PH_HEAT && !cmp_hi);
  assign ovp_nxt = ovp_q | (judge && phase == PH_VOLT &&  cmp_hi);

  always_ff @(posedge clk) begin
    if (rst) begin
      otp_q <= 1'b0;
      ovp_q <= 1'b0;
    end else begin
      otp_q <= otp_nxt;
      ovp_q <= ovp_nxt;
    end
  end
endmodule

// File: rtl/sdm_monitor.sv
module sdm_monitor
  import sdm_pkg::*;
#(
  parameter int PH_CYCLES = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic cyc_start,
  input  logic startup,
  input  logic cmp_hi,
  output logic src_sel,
  output logic thr_hi,
  output logic otp_fault,
  output logic ovp_fault,
  output logic shutdown
);
  phase_t phase, phase_nxt;
  logic   at_last, otp_nxt, ovp_nxt;

  sdm_phase_ctr #(.PH_CYCLES(PH_CYCLES)) u_ctr (
    .clk(clk), .rst(rst), .adv(cyc_start),
    .phase(phase), .phase_nxt(phase_nxt), .at_last(at_last)
  );

  sdm_fault_judge u_judge (
    .clk(clk), .rst(rst), .judge(cyc_start && at_last),
    .phase(phase), .cmp_hi(cmp_hi),
    .otp_q(otp_fault), .ovp_q(ovp_fault),
    .otp_nxt(otp_nxt), .ovp_nxt(ovp_nxt)
  );

  assign src_sel = (phase == PH_HEAT);

  always_ff @(posedge clk) begin
    if (rst) begin
      thr_hi   <= 1'b0;
      shutdown <= 1'b0;
    end else begin
      thr_hi   <= startup && (phase_nxt == PH_HEAT);
      shutdown <= otp_nxt | ovp_nxt;
    end
  end
endmodule

// File: rtl/sdm_monitor_chk.sv
module sdm_monitor_chk (
  input logic clk,
  input logic rst,
  input logic cyc_start,
  input logic cmp_hi,
  input logic src_sel,
  input logic thr_hi,
  input logic otp_fault,
  input logic ovp_fault,
  input logic shutdown
);
  assert_sel_on_strobe_R2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(cyc_start)) |-> $stable(src_sel));

  assert_otp_cause_R3: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $rose(otp_fault)) |-> ($past(src_sel) && $past(cyc_start) && !$past(cmp_hi)));

  assert_ovp_cause_R4: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $rose(ovp_fault)) |-> (!$past(src_sel) && $past(cyc_start) && $past(cmp_hi)));

  assert_thr_in_heat_R7: assert property (@(posedge clk) disable iff (rst)
    thr_hi |-> src_sel);

  assert_otp_hold_R8: assert property (@(posedge clk) disable iff (rst)
    otp_fault |=> otp_fault);

  assert_ovp_hold_R8: assert property (@(posedge clk) disable iff (rst)
    ovp_fault |=> ovp_fault);

  assert_shutdown_or_R9: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (shutdown == (otp_fault || ovp_fault)));
endmodule

bind sdm_monitor sdm_monitor_chk u_chk (
  .clk(clk), .rst(rst), .cyc_start(cyc_start), .cmp_hi(cmp_hi),
  .src_sel(src_sel), .thr_hi(thr_hi), .otp_fault(otp_fault),
  .ovp_fault(ovp_fault), .shutdown(shutdown)
);

// File: tb/sim_sdm_monitor.sv
module sim_sdm_monitor;
  localparam int CLK_PERIOD = 10;
  localparam int N = 4;

  logic clk = 1'b0;
  logic rst, cyc_start, startup, cmp_hi;
  logic src_sel, thr_hi, otp_fault, ovp_fault, shutdown;
  int   errors = 0;
  int   checks = 0;
  bit   done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdm_monitor #(.PH_CYCLES(N)) u0 (
    .clk(clk), .rst(rst), .cyc_start(cyc_start), .startup(startup),
    .cmp_hi(cmp_hi), .src_sel(src_sel), .thr_hi(thr_hi),
    .otp_fault(otp_fault), .ovp_fault(ovp_fault), .shutdown(shutdown)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic heat_of(input int s);
    return ((s / N) % 2) == 0;
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; cyc_start = 1'b0; cmp_hi = 1'b1; startup = 1'b0;
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic strobe(input logic v);
    cyc_start = 1'b1; cmp_hi = v;
    @(negedge clk);
    cyc_start = 1'b0;
  endtask

  initial begin
    rst = 1'b1; cyc_start = 1'b0; startup = 1'b0; cmp_hi = 1'b1;
    do_reset();
    // R1 reset state
    chk("R1 src_sel", src_sel, 1'b1);
    chk("R1 thr_hi", thr_hi, 1'b0);
    chk("R1 otp_fault", otp_fault, 1'b0);
    chk("R1 ovp_fault", ovp_fault, 1'b0);
    chk("R1 shutdown", shutdown, 1'b0);

    // Sweep the judged value over every strobe position of two phases
    for (int k = 0; k < 2*N; k++) begin
      for (int v = 0; v < 2; v++) begin
        logic e_otp, e_ovp;
        do_reset();
        for (int s = 0; s < k; s++) begin
          strobe(heat_of(s));
          chk("R2 src_sel", src_sel, heat_of(s + 1));
          chk("R6 no fault on passing level", shutdown, 1'b0);
        end
        strobe(v[0]);
        e_otp = heat_of(k) && (k % N == N-1) && (v == 0);
        e_ovp = !heat_of(k) && (k % N == N-1) && (v == 1);
        chk("R3 otp_fault", otp_fault, e_otp);
        chk("R4 ovp_fault", ovp_fault, e_ovp);
        chk("R5 off-window sample ignored", otp_fault | ovp_fault, e_otp | e_ovp);
        chk("R9 shutdown", shutdown, e_otp | e_ovp);
      end
    end

    // R5: failing levels without a strobe, at the last heat cycle
    do_reset();
    for (int s = 0; s < N-1; s++) strobe(1'b1);
    cmp_hi = 1'b0;
    repeat (5) @(negedge clk);
    chk("R5 idle low ignored otp", otp_fault, 1'b0);
    chk("R5 idle src_sel held R2", src_sel, 1'b1);
    strobe(1'b0);
    chk("R3 otp at last strobe", otp_fault, 1'b1);
    // R8 latch through following strobes of both phases
    for (int s = 0; s < 2*N; s++) strobe(heat_of(s + N));
    chk("R8 otp held", otp_fault, 1'b1);
    chk("R9 shutdown held", shutdown, 1'b1);
    chk("R6 ovp clear", ovp_fault, 1'b0);
    do_reset();
    chk("R8 otp cleared by rst", otp_fault, 1'b0);

    // R7 reference select
    startup = 1'b1;
    @(negedge clk);
    chk("R7 thr_hi heat+startup", thr_hi, 1'b1);
    for (int s = 0; s < N-1; s++) strobe(1'b1);
    chk("R7 thr_hi still heat", thr_hi, 1'b1);
    strobe(1'b1);
    chk("R7 thr_hi low in volt phase", thr_hi, 1'b0);
    chk("R2 volt phase", src_sel, 1'b0);
    for (int s = 0; s < N; s++) strobe(1'b0);
    chk("R7 thr_hi back in heat", thr_hi, 1'b1);
    startup = 1'b0;
    @(negedge clk);
    chk("R7 thr_hi drops with startup", thr_hi, 1'b0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule